// File: doc/BRIEF.md
# Dual-Strobe EDO DRAM Device Model

This block is a synthesizable model of the device side of an extended-data-out DRAM with two byte-lane column strobes. The array depth is reduced by parameter. A controller under test drives the active-low row strobe, the two column strobes, the write and output enables, a 9-bit multiplexed address and 16 bits of write data. The model samples all of them on a fast clock and acts on the edges it sees: it latches rows and columns, moves data per byte lane, and works out the refresh type from the order in which the strobes fall.

A row strobe that falls while both column strobes are high opens an access cycle. A row strobe that falls while either column strobe is already low is a refresh. That refresh takes its row from an internal 9-bit counter, which then advances. A row cycle that ends with no column strobe ever falling counts as a refresh of the row on the address pins. The read data is held on a 16-bit output with a per-lane enable instead of a tristate net. It stays valid through column precharge and through a hidden refresh. A sticky flag records two ordering errors: a column strobe that falls too early after the row strobe, and a row pulse that is too short.

Top module: `edo_dram_model`

## Requirements
- R1: A falling ras_n sampled with casl_n and cash_n both high latches addr as the row. A later falling column strobe, seen after a sample with both column strobes high, latches addr as the column. The word index is {row[ROW_BITS-1:0], column[COL_BITS-1:0]} (3 and 3 by default).
- R2: casl_n controls lane 0 (data bits 7:0, enable dq_oe[0]) and cash_n controls lane 1 (bits 15:8, dq_oe[1]). A lane whose column strobe does not fall is neither written nor read, and its stored byte is left unchanged.
- R3: A falling ras_n sampled while either column strobe is low is a counter refresh. One cycle later refresh_done is high for one cycle and refreshed_row equals the counter value before the event. The counter then reads one higher, addr is ignored and no data lane changes.
- R4: A row cycle (ras_n low, then high) opened as an access in which no column strobe falls is a row-only refresh. In the cycle after the rising ras_n is sampled, refresh_done pulses and refreshed_row equals the full 9-bit latched row. ref_cnt does not change.
- R5: ref_cnt is 9 bits wide and resets to 0. After 512 counter refreshes it returns to its starting value, and each of the 512 reports a distinct row in increasing order.
- R6: A read sets the lane's data as valid. dq_oe for that lane is high while the data is valid and oe_n is low, and low whenever oe_n is high. The data stays valid through column precharge while ras_n is low. It is cleared after a sample where ras_n and the lane's column strobe are both high, or where we_n falls.
- R7: Hidden refresh: when ras_n goes high and then low while the column strobes stay low after a read, the second fall is treated as a counter refresh (R3). No row-only refresh is reported, and dq_out and dq_oe keep the read data.
- R8: A column strobe falling with we_n low stores that lane of dq_in. With we_n high, it loads that lane of dq_out from the stored word within one cycle.
- R9: timing_viol is set if an access column strobe falls fewer than T_RCD samples after the row-strobe fall sample (default 2). It is also set if ras_n rises fewer than T_RAS samples after it fell (default 4). It stays set until reset.
- R10: After reset, dq_oe, refresh_done, timing_viol and ref_cnt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Column strobe for lane 0, active low |
| cash_n | input | 1 | Column strobe for lane 1, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Held read data |
| dq_oe | output | 2 | Per-lane output enable |
| ref_cnt | output | 9 | Internal refresh row counter |
| refresh_done | output | 1 | One-cycle pulse per refresh |
| refreshed_row | output | 9 | Row refreshed by the last pulse |
| timing_viol | output | 1 | Sticky ordering violation flag |

## Verification
If the edge decoder took the wrong cycle type, the error would show at the ports within one cycle of the deciding row-strobe edge. A wrong refresh_done, a wrong refreshed_row, or a ref_cnt that moves when it should not would all be visible there. A wrong stored word or lane mask stays hidden until the next read of that word, so the sweep writes every word and then reads every word back through both lanes. An output-valid flag that does not clear would show as dq_oe staying high one cycle after the strobes close, and one that clears too early would show during column precharge or a hidden refresh.

// File: rtl/edo_dram_pkg.sv
package edo_dram_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_ACCESS,
        CYC_REFRESH
    } cyc_e;

    typedef struct packed {
        logic       ras_n;
        logic [1:0] cas_n;   // [0] lower lane, [1] upper lane
        logic       we_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 2'b11, we_n: 1'b1};

    function automatic logic edge_fall(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

    function automatic logic edge_rise(input logic prev, input logic cur);
        return ~prev & cur;
    endfunction

endpackage

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [ROW_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)          count <= '0;
        else if (advance) count <= count + 1'b1;
    end
endmodule

// File: rtl/edo_cycle_ctrl.sv
module edo_cycle_ctrl
    import edo_dram_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3,
    parameter int T_RCD    = 2,
    parameter int T_RAS    = 4,
    localparam int IDX_W   = ROW_BITS + COL_BITS,
    localparam int CNT_MAX = (T_RAS > T_RCD) ? T_RAS : T_RCD,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           strb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ref_cnt,
    output logic              ref_advance,
    output logic [1:0]        lane_acc,
    output logic [1:0]        lane_clr,
    output logic [IDX_W-1:0]  word_idx,
    output logic              refresh_done,
    output logic [ADDR_W-1:0] refreshed_row,
    output logic              timing_viol
);
    strobe_t             prev_q;
    cyc_e                mode_q;
    logic [ADDR_W-1:0]   row_q;
    logic [COL_BITS-1:0] col_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                xfer_q;

    logic       ras_fall, ras_rise, we_fall, first_cas;
    logic [1:0] cas_fall;

    always_comb begin
        ras_fall  = edge_fall(prev_q.ras_n, strb.ras_n);
        ras_rise  = edge_rise(prev_q.ras_n, strb.ras_n);
        we_fall   = edge_fall(prev_q.we_n, strb.we_n);
        for (int i = 0; i < 2; i++)
            cas_fall[i] = edge_fall(prev_q.cas_n[i], strb.cas_n[i]);
        first_cas   = (|cas_fall) & (&prev_q.cas_n);
        lane_acc    = (mode_q == CYC_ACCESS && !ras_fall) ? cas_fall : 2'b00;
        ref_advance = ras_fall & ~(&strb.cas_n);
        word_idx    = {row_q[ROW_BITS-1:0], first_cas ? addr[COL_BITS-1:0] : col_q};
        for (int i = 0; i < 2; i++)
            lane_clr[i] = (strb.ras_n & strb.cas_n[i]) | we_fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q        <= STROBE_IDLE;
            mode_q        <= CYC_IDLE;
            row_q         <= '0;
            col_q         <= '0;
            cnt_q         <= '0;
            xfer_q        <= 1'b0;
            refresh_done  <= 1'b0;
            refreshed_row <= '0;
            timing_viol   <= 1'b0;
        end else begin
            prev_q       <= strb;
            refresh_done <= 1'b0;
            if (ras_fall) begin
                cnt_q  <= CNT_W'(1);
                xfer_q <= 1'b0;
                if (&strb.cas_n) begin
                    mode_q <= CYC_ACCESS;
                    row_q  <= addr;
                end else begin
                    mode_q        <= CYC_REFRESH;
                    refresh_done  <= 1'b1;
                    refreshed_row <= ref_cnt;
                end
            end else if (!strb.ras_n && cnt_q != CNT_W'(CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (|lane_acc) begin
                xfer_q <= 1'b1;
                if (cnt_q < CNT_W'(T_RCD)) timing_viol <= 1'b1;
                if (first_cas) col_q <= addr[COL_BITS-1:0];
            end
            if (ras_rise) begin
                mode_q <= CYC_IDLE;
                if (cnt_q < CNT_W'(T_RAS)) timing_viol <= 1'b1;
                if (mode_q == CYC_ACCESS && !xfer_q) begin
                    refresh_done  <= 1'b1;
                    refreshed_row <= row_q;
                end
            end
        end
    end

    assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        $past(timing_viol) |-> timing_viol);

endmodule

// File: rtl/edo_lane_store.sv
module edo_lane_store #(
    parameter int IDX_W  = 6,
    parameter int LANE_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              we_n,
    input  logic              clr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout,
    output logic              valid
);
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (acc && !we_n) mem[idx] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
        end else if (acc) begin
            if (we_n) begin
                dout  <= mem[idx];
                valid <= 1'b1;
            end else begin
                valid <= 1'b0;
            end
        end else if (clr) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
    import edo_dram_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 16,
    parameter int ROW_BITS = 3,
    parameter int COL_BITS = 3,
    parameter int T_RCD    = 2,
    parameter int T_RAS    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              casl_n,
    input  logic              cash_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [1:0]        dq_oe,
    output logic [ADDR_W-1:0] ref_cnt,
    output logic              refresh_done,
    output logic [ADDR_W-1:0] refreshed_row,
    output logic              timing_viol
);
    localparam int IDX_W  = ROW_BITS + COL_BITS;
    localparam int LANE_W = DATA_W / 2;

    strobe_t          strb;
    logic             ref_advance;
    logic [1:0]       lane_acc, lane_clr, lane_valid;
    logic [IDX_W-1:0] word_idx;
    logic [1:0]       lane_cas_n;

    assign strb       = '{ras_n: ras_n, cas_n: {cash_n, casl_n}, we_n: we_n};
    assign lane_cas_n = {cash_n, casl_n};

    edo_refresh_ctr #(.ROW_W(ADDR_W)) u_refresh (
        .clk(clk), .rst(rst), .advance(ref_advance), .count(ref_cnt)
    );

    edo_cycle_ctrl #(
        .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS),
        .T_RCD(T_RCD), .T_RAS(T_RAS)
    ) u_ctrl (
        .clk(clk), .rst(rst), .strb(strb), .addr(addr), .ref_cnt(ref_cnt),
        .ref_advance(ref_advance), .lane_acc(lane_acc), .lane_clr(lane_clr),
        .word_idx(word_idx), .refresh_done(refresh_done),
        .refreshed_row(refreshed_row), .timing_viol(timing_viol)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        edo_lane_store #(.IDX_W(IDX_W), .LANE_W(LANE_W)) u_store (
            .clk(clk), .rst(rst), .acc(lane_acc[g]), .we_n(we_n),
            .clr(lane_clr[g]), .idx(word_idx),
            .din(dq_in[g*LANE_W +: LANE_W]),
            .dout(dq_out[g*LANE_W +: LANE_W]),
            .valid(lane_valid[g])
        );
        assign dq_oe[g] = lane_valid[g] & ~oe_n;

        // R6: a closed lane has no driven data one cycle later
        assert_oe_release_R6: assert property (@(posedge clk) disable iff (rst)
            $past(ras_n && lane_cas_n[g]) |-> !dq_oe[g]);

        // R2: a lane's output data moves only after its own strobe was low
        assert_lane_hold_R2: assert property (@(posedge clk) disable iff (rst)
            $past(lane_cas_n[g]) |-> $stable(dq_out[g*LANE_W +: LANE_W]));
    end

    assert_ref_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (ref_cnt != $past(ref_cnt)) |-> (refresh_done && ref_cnt == $past(ref_cnt) + 1'b1));

endmodule

// File: tb/test_edo_dram_model.sv
module test_edo_dram_model;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ras_n = 1'b1, casl_n = 1'b1, cash_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [8:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic [8:0]  ref_cnt, refreshed_row;
    logic        refresh_done, timing_viol;

    int n_run = 0, n_fail = 0;
    logic [15:0] rd;
    logic [1:0]  roe;

    always #4 clk = ~clk;

    edo_dram_model i_edo_dram_model (
        .clk(clk), .rst(rst), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .ref_cnt(ref_cnt), .refresh_done(refresh_done),
        .refreshed_row(refreshed_row), .timing_viol(timing_viol)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] pat(input int r, input int c);
        return {8'(r * 16 + c + 3), 8'(~(r * 8 + c))};
    endfunction

    // one row cycle with a single column access; lanes: bit0 lower, bit1 upper
    task automatic access(input logic [8:0] row, input logic [8:0] col,
                          input logic [1:0] lanes, input logic wr, input logic [15:0] d);
        addr = row;
        cyc(1); ras_n = 1'b0;
        cyc(2);
        addr = col; we_n = ~wr; oe_n = wr; dq_in = d;
        casl_n = ~lanes[0]; cash_n = ~lanes[1];
        cyc(1);
        rd = dq_out; roe = dq_oe;
        cyc(3);
        ras_n = 1'b1; casl_n = 1'b1; cash_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        cyc(2);
    endtask

    task automatic cbr(input logic [8:0] junk_addr, input logic [8:0] exp_row);
        addr = junk_addr; casl_n = 1'b0;
        cyc(1); ras_n = 1'b0;
        cyc(1);
        chk("R3 cbr pulse", refresh_done, 1'b1);
        chk("R5 cbr row order", refreshed_row, exp_row);
        chk("R3 counter step", ref_cnt, 9'(exp_row + 1));
        cyc(4); ras_n = 1'b1;
        cyc(1); casl_n = 1'b1;
        cyc(1);
    endtask

    initial begin
        logic [8:0] c0;
        cyc(4); rst = 1'b0; cyc(1);
        // R10
        chk("R10 dq_oe", dq_oe, 2'b00);
        chk("R10 ref_cnt", ref_cnt, 9'd0);
        chk("R10 refresh_done", refresh_done, 1'b0);
        chk("R10 timing_viol", timing_viol, 1'b0);

        // R1 R8: full word sweep
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                access(9'(r), 9'(c), 2'b11, 1'b1, pat(r, c));
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                access(9'(r), 9'(c), 2'b11, 1'b0, 16'h0);
                chk("R1 R8 word readback", rd, pat(r, c));
                chk("R6 both lanes enabled", roe, 2'b11);
            end
        chk("R9 no violation on legal cycles", timing_viol, 1'b0);

        // R2: lane-only writes and reads
        access(9'd2, 9'd5, 2'b01, 1'b1, 16'hBEEF);
        access(9'd2, 9'd5, 2'b11, 1'b0, 16'h0);
        chk("R2 lower write only", rd, {pat(2, 5)[15:8], 8'hEF});
        access(9'd6, 9'd1, 2'b10, 1'b1, 16'hC3A5);
        access(9'd6, 9'd1, 2'b11, 1'b0, 16'h0);
        chk("R2 upper write only", rd, {8'hC3, pat(6, 1)[7:0]});
        access(9'd6, 9'd1, 2'b10, 1'b0, 16'h0);
        chk("R2 upper read enable", roe, 2'b10);
        chk("R2 upper read data", rd[15:8], 8'hC3);
        access(9'd3, 9'd3, 2'b01, 1'b0, 16'h0);
        chk("R2 lower read enable", roe, 2'b01);
        chk("R2 lower read data", rd[7:0], pat(3, 3)[7:0]);

        // R6: EDO hold, OE gating, release by WE fall and by strobes high
        addr = 9'd4; cyc(1); ras_n = 1'b0; cyc(2);
        addr = 9'd7; oe_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; cyc(1);
        casl_n = 1'b1; cash_n = 1'b1; cyc(2);
        chk("R6 held in precharge oe", dq_oe, 2'b11);
        chk("R6 held in precharge data", dq_out, pat(4, 7));
        oe_n = 1'b1; #1;
        chk("R6 oe high disables", dq_oe, 2'b00);
        oe_n = 1'b0; #1;
        chk("R6 oe low re-enables", dq_oe, 2'b11);
        we_n = 1'b0; cyc(1);
        chk("R6 we fall releases", dq_oe, 2'b00);
        ras_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; cyc(2);
        access(9'd1, 9'd1, 2'b11, 1'b0, 16'h0);
        chk("R6 read after close", rd, pat(1, 1));
        cyc(1);
        chk("R6 released after ras and cas high", dq_oe, 2'b00);

        // R4: row-only refresh
        c0 = ref_cnt;
        addr = 9'h1A5; cyc(1); ras_n = 1'b0; cyc(5); ras_n = 1'b1; cyc(1);
        chk("R4 row-only pulse", refresh_done, 1'b1);
        chk("R4 row-only row", refreshed_row, 9'h1A5);
        chk("R4 counter unchanged", ref_cnt, c0);
        cyc(1);
        chk("R4 pulse single", refresh_done, 1'b0);
        access(9'h1A5, 9'd0, 2'b11, 1'b0, 16'h0);
        chk("R4 no data transfer", rd, pat(5, 0));

        // R3 R5: 512 counter refreshes wrap the counter
        c0 = ref_cnt;
        for (int k = 0; k < 512; k++) cbr(9'(k * 37), 9'(c0 + 9'(k)));
        chk("R5 wrap", ref_cnt, c0);
        access(9'd0, 9'd0, 2'b11, 1'b0, 16'h0);
        chk("R3 data untouched", rd, pat(0, 0));

        // R7: hidden refresh
        c0 = ref_cnt;
        addr = 9'd7; cyc(1); ras_n = 1'b0; cyc(2);
        addr = 9'd2; oe_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; cyc(5);
        ras_n = 1'b1; cyc(2);
        chk("R7 no row-only pulse", refresh_done, 1'b0);
        chk("R7 oe kept while ras high", dq_oe, 2'b11);
        ras_n = 1'b0; addr = 9'h0F0; cyc(1);
        chk("R7 hidden pulse", refresh_done, 1'b1);
        chk("R7 hidden row", refreshed_row, c0);
        chk("R7 counter step", ref_cnt, 9'(c0 + 1));
        chk("R7 data kept", dq_out, pat(7, 2));
        chk("R7 oe kept", dq_oe, 2'b11);
        cyc(5); ras_n = 1'b1; cyc(1);
        casl_n = 1'b1; cash_n = 1'b1; oe_n = 1'b1; cyc(2);
        chk("R7 released at end", dq_oe, 2'b00);
        chk("R9 clean after hidden", timing_viol, 1'b0);

        // R9: early CAS
        addr = 9'd1; cyc(1); ras_n = 1'b0; cyc(1);
        casl_n = 1'b0; cyc(1);
        chk("R9 early cas", timing_viol, 1'b1);
        cyc(4); ras_n = 1'b1; casl_n = 1'b1; cyc(3);
        chk("R9 sticky", timing_viol, 1'b1);
        rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
        chk("R10 viol cleared", timing_viol, 1'b0);
        // R9: short RAS
        cyc(1); ras_n = 1'b0; cyc(2); ras_n = 1'b1; cyc(1);
        chk("R9 short ras", timing_viol, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule